// File: doc/BRIEF.md
# Earliest-Deadline Cell Link Scheduler

This block chooses which queued cell goes out next on one output link of a cell switch serving a parameterised number of channels. Each arriving cell brings a channel number, a deadline and an eligibility time. The block keeps cells as tags only, with no payload.

All channels share one pool of cell slots. Each channel's cells form a linked FIFO inside that pool, and a free list tracks the unused slots. A channel may hold any number of cells, up to the whole pool. For each non-empty channel, only the cell at the head of its FIFO is copied into a small per-channel candidate set, and the choice is made from that set.

On every link slot the block picks, among the candidates that are eligible, the one with the earliest deadline and emits it. Deadlines and times wrap around. They are compared through the sign of their modular difference, so the time fields never need widening.

Top module: `edf_link_sched`

## Requirements
- R1: After reset `out_valid` is low, every bit of `chan_empty` is high, `free_slots` equals NSLOT and `in_ready` is high.
- R2: When `slot_tick` is high at a clock edge and at least one channel has an eligible head cell, the outputs registered at that edge carry `out_valid`=1 and the channel and deadline of the eligible head cell with the earliest deadline. That cell leaves its queue.
- R3: When eligible head cells have equal deadlines, the one on the lowest-numbered channel is emitted first.
- R4: A head cell whose eligibility time is later than `now` is not emitted. It is eligible when (elig − now) mod 2^TW is zero or has its top bit set. When no cell is eligible at a tick, `out_valid` is low for that slot.
- R5: Cells of one channel leave in arrival order, even when a later cell of that channel has an earlier deadline.
- R6: Deadline a is earlier than deadline b when the top bit of (a − b) mod 2^TW is set. For example, with TW=8, 0xF0 comes before 0x02.
- R7: One channel may fill all NSLOT slots. When no slot is free, `in_ready` is low and a cell presented on `in_valid` is not stored.
- R8: `free_slots` falls by one for each accepted cell and rises by one for each emitted cell. An accept and an emit in the same cycle leave it unchanged. `chan_empty[c]` is high exactly when channel c holds no cell.
- R9: A clock edge with `slot_tick` low registers `out_valid` low.
- R10: When a cell arrives for a channel in the same cycle that the channel's last cell is emitted, the new cell becomes that channel's head and can be emitted at a later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TW | Current wrapping time |
| slot_tick | input | 1 | Link slot strobe; requests one emission |
| in_valid | input | 1 | Arriving cell present |
| in_ready | output | 1 | A free slot exists |
| in_chan | input | CW | Channel of arriving cell |
| in_dl | input | TW | Deadline of arriving cell |
| in_elig | input | TW | Eligibility time of arriving cell |
| out_valid | output | 1 | A cell was emitted this slot |
| out_chan | output | CW | Channel of emitted cell |
| out_dl | output | TW | Deadline of emitted cell |
| chan_empty | output | NCH | Per-channel empty flags |
| free_slots | output | $clog2(NSLOT+1) | Number of unused cell slots |

## Verification
The hardest case to reach is an arrival and an emission in the same cycle, on a channel whose only cell is being emitted. In that cycle the head pointer, the free list and the candidate entry are all rewritten by both operations at once. The bench reaches it by loading a single cell and then pulsing `slot_tick` in the same cycle as a new arrival on that channel, checking both the emitted cell and the later emission of the newcomer.

A second hard case is the full pool, where a refused arrival must leave no trace. The bench fills every slot from one channel, presents an extra cell while `in_ready` is low, and then drains the channel to show that exactly NSLOT cells come out, in order.

// File: rtl/edf_link_sched.sv
module edf_link_sched #(
  parameter int NCH   = 4,
  parameter int NSLOT = 8,
  parameter int TW    = 8,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int NW   = $clog2(NSLOT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  now,
  input  logic           slot_tick,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CW-1:0]  in_chan,
  input  logic [TW-1:0]  in_dl,
  input  logic [TW-1:0]  in_elig,
  output logic           out_valid,
  output logic [CW-1:0]  out_chan,
  output logic [TW-1:0]  out_dl,
  output logic [NCH-1:0] chan_empty,
  output logic [NW-1:0]  free_slots
);

  logic [TW-1:0] dl_mem [NSLOT];
  logic [TW-1:0] el_mem [NSLOT];
  logic [SW-1:0] link   [NSLOT];
  logic [SW-1:0] hd [NCH];
  logic [SW-1:0] tl [NCH];
  logic [NW-1:0] cnt [NCH];
  logic [TW-1:0] cand_dl [NCH];
  logic [TW-1:0] cand_el [NCH];
  logic [SW-1:0] fhead;

  logic          pick_v;
  logic [CW-1:0] pick_c;
  logic [TW-1:0] pick_d;
  logic [TW-1:0] ediff, ddiff;

  always_comb begin
    pick_v = 1'b0;
    pick_c = '0;
    pick_d = '0;
    ediff  = '0;
    ddiff  = '0;
    for (int c = 0; c < NCH; c++) begin
      ediff = cand_el[c] - now;
      ddiff = cand_dl[c] - pick_d;
      if (cnt[c] != '0 && (ediff == '0 || ediff[TW-1])) begin
        if (!pick_v || ddiff[TW-1]) begin
          pick_v = 1'b1;
          pick_c = CW'(c);
          pick_d = cand_dl[c];
        end
      end
    end
  end

  wire          enq  = in_valid && in_ready;
  wire          deq  = slot_tick && pick_v;
  wire [SW-1:0] sfree = hd[pick_c];
  wire [SW-1:0] snext = link[sfree];
  wire [SW-1:0] fnext = link[fhead];
  wire          emptying = deq && pick_c == in_chan && cnt[in_chan] == NW'(1);

  assign in_ready = free_slots != '0;

  always_comb
    for (int c = 0; c < NCH; c++) chan_empty[c] = cnt[c] == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_dl     <= '0;
      fhead      <= '0;
      free_slots <= NW'(NSLOT);
      for (int i = 0; i < NSLOT; i++) begin
        link[i]   <= SW'((i + 1) % NSLOT);
        dl_mem[i] <= '0;
        el_mem[i] <= '0;
      end
      for (int c = 0; c < NCH; c++) begin
        hd[c]      <= '0;
        tl[c]      <= '0;
        cnt[c]     <= '0;
        cand_dl[c] <= '0;
        cand_el[c] <= '0;
      end
    end else begin
      out_valid  <= deq;
      if (deq) begin
        out_chan <= pick_c;
        out_dl   <= pick_d;
      end
      free_slots <= free_slots - NW'(enq) + NW'(deq);
      for (int c = 0; c < NCH; c++)
        cnt[c] <= cnt[c] + NW'(enq && in_chan == CW'(c)) - NW'(deq && pick_c == CW'(c));

      if (deq && cnt[pick_c] > NW'(1)) begin
        hd[pick_c]      <= snext;
        cand_dl[pick_c] <= dl_mem[snext];
        cand_el[pick_c] <= el_mem[snext];
      end

      if (enq) begin
        dl_mem[fhead] <= in_dl;
        el_mem[fhead] <= in_elig;
        tl[in_chan]   <= fhead;
        if (cnt[in_chan] == '0 || emptying) begin
          hd[in_chan]      <= fhead;
          cand_dl[in_chan] <= in_dl;
          cand_el[in_chan] <= in_elig;
        end else begin
          link[tl[in_chan]] <= fhead;
        end
      end

      if (deq && enq) begin
        link[sfree] <= fnext;
        fhead       <= sfree;
      end else if (deq) begin
        link[sfree] <= fhead;
        fhead       <= sfree;
      end else if (enq) begin
        fhead <= fnext;
      end
    end
  end

  logic [NW+CW:0] occ_sum;
  always_comb begin
    occ_sum = (NW+CW+1)'(free_slots);
    for (int c = 0; c < NCH; c++) occ_sum = occ_sum + (NW+CW+1)'(cnt[c]);
  end

  p_slot_total_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ_sum == (NW+CW+1)'(NSLOT));

  p_refuse_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots == '0 |-> !in_ready);

  p_tick_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> !out_valid);

  p_emit_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (deq && !enq) |=> free_slots == $past(free_slots) + NW'(1));

  p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots == NW'(NSLOT) |-> &chan_empty);

  p_eligible_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && &chan_empty) |=> !out_valid);

endmodule

// File: tb/tb_edf_link_sched.sv
module tb_edf_link_sched;
  localparam int NCH = 4, NSLOT = 8, TW = 8, CW = 2, NW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] now = '0;
  logic slot_tick = 1'b0, in_valid = 1'b0, in_ready, out_valid;
  logic [CW-1:0] in_chan = '0, out_chan;
  logic [TW-1:0] in_dl = '0, in_elig = '0, out_dl;
  logic [NCH-1:0] chan_empty;
  logic [NW-1:0] free_slots;
  int applied = 0, bad = 0;

  always #2 clk = ~clk;

  edf_link_sched #(.NCH(NCH), .NSLOT(NSLOT), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .now(now), .slot_tick(slot_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
    .in_dl(in_dl), .in_elig(in_elig), .out_valid(out_valid),
    .out_chan(out_chan), .out_dl(out_dl), .chan_empty(chan_empty),
    .free_slots(free_slots));

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int ch, input int dl, input int el);
    @(negedge clk);
    in_valid = 1'b1; in_chan = CW'(ch); in_dl = TW'(dl); in_elig = TW'(el);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tick(input string req, input bit v, input int ch, input int dl);
    @(negedge clk);
    slot_tick = 1'b1;
    @(negedge clk);
    slot_tick = 1'b0;
    chk({req, " valid"}, int'(out_valid), int'(v));
    if (v) begin
      chk({req, " chan"}, int'(out_chan), ch);
      chk({req, " deadline"}, int'(out_dl), dl);
    end
  endtask

  task automatic t_reset;
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 chan_empty", int'(chan_empty), 15);
    chk("R1 free_slots", int'(free_slots), NSLOT);
    chk("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_basic;
    now = 8'd10;
    push(1, 50, 0); push(2, 30, 0); push(0, 40, 0);
    chk("R8 free after 3", int'(free_slots), NSLOT - 3);
    chk("R8 empty flags", int'(chan_empty), 8);
    tick("R2 first", 1, 2, 30);
    tick("R2 second", 1, 0, 40);
    tick("R2 third", 1, 1, 50);
    tick("R4 none left", 0, 0, 0);
    chk("R8 free restored", int'(free_slots), NSLOT);
  endtask

  task automatic t_tie;
    push(3, 60, 0); push(1, 60, 0);
    tick("R3 low chan", 1, 1, 60);
    tick("R3 high chan", 1, 3, 60);
  endtask

  task automatic t_early;
    now = 8'd20;
    push(0, 25, 30);
    tick("R4 early held", 0, 0, 0);
    now = 8'd30;
    tick("R4 now eligible", 1, 0, 25);
  endtask

  task automatic t_fifo;
    push(2, 90, 0); push(2, 70, 0); push(1, 80, 0);
    tick("R5 a", 1, 1, 80);
    tick("R5 b", 1, 2, 90);
    tick("R5 c", 1, 2, 70);
  endtask

  task automatic t_wrap;
    now = 8'hE8;
    push(0, 8'h02, 8'hE0); push(1, 8'hF0, 8'hE0);
    tick("R6 before wrap", 1, 1, 8'hF0);
    tick("R6 after wrap", 1, 0, 8'h02);
  endtask

  task automatic t_notick;
    push(2, 8'hF8, 8'hE0);
    @(negedge clk);
    chk("R9 no tick", int'(out_valid), 0);
    tick("R9 then tick", 1, 2, 8'hF8);
  endtask

  task automatic t_full;
    now = 8'd0;
    for (int i = 1; i <= NSLOT; i++) push(3, i, 0);
    chk("R7 free zero", int'(free_slots), 0);
    chk("R7 ready low", int'(in_ready), 0);
    chk("R7 chan3 busy", int'(chan_empty[3]), 0);
    push(3, 0, 0);
    chk("R7 refused", int'(free_slots), 0);
    for (int i = 1; i <= NSLOT; i++) tick("R7 drain", 1, 3, i);
    tick("R7 nothing extra", 0, 0, 0);
    chk("R7 free back", int'(free_slots), NSLOT);
  endtask

  task automatic t_simul;
    now = 8'd5;
    push(0, 11, 0);
    @(negedge clk);
    slot_tick = 1'b1; in_valid = 1'b1; in_chan = 2'd0; in_dl = 8'd22; in_elig = 8'd0;
    @(negedge clk);
    slot_tick = 1'b0; in_valid = 1'b0;
    chk("R10 emitted old", int'(out_dl), 11);
    chk("R10 emitted valid", int'(out_valid), 1);
    chk("R8 free unchanged", int'(free_slots), NSLOT - 1);
    chk("R10 chan0 busy", int'(chan_empty[0]), 0);
    tick("R10 newcomer", 1, 0, 22);
    chk("R8 empty at end", int'(chan_empty), 15);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_tie;
    t_early;
    t_fifo;
    t_wrap;
    t_notick;
    t_full;
    t_simul;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule